// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes of a microcontroller's multiplexed external bus: an active-high address strobe, which tells an external latch when to capture the low address byte, and an active-low code-read strobe, which enables external program memory onto the bus. It divides each machine cycle into twelve oscillator phases and exposes the running phase so that neighbouring logic, such as port drivers or the sequencer, can line its own actions up with the strobes.

The sequencer gives the block one description per machine cycle: what kind of bus traffic the cycle carries (internal code fetch, external code fetch, external data access, or no bus use), and whether the cycle belongs to an external data move or code-table read instruction. It also supplies a software-controlled bit that silences the address strobe and a flag that says the core runs from external program memory. The block samples these inputs on the last phase of a cycle. They apply to the whole of the following cycle, so a change in the middle of a cycle cannot cut a strobe short. By default the address strobe runs at one sixth of the oscillator rate and can serve as a clock for off-chip logic.

Top module: `bus_strobe_gen`

## Requirements
- R1: `phase_o` resets to 0, then counts 0,1,...,11 and wraps back to 0, one step per clock.
- R2: While `rst_ni` is low, `phase_o` is 0, `addr_strobe_o` is 1 and `code_rd_no` is 1.
- R3: With the strobe enabled, `addr_strobe_o` is high exactly in phases 0, 1, 6 and 7 of every cycle that is not an external data access (kind 2'b10). This is one pulse per six oscillator clocks.
- R4: In an external data access cycle (kind 2'b10), the address pulse in phases 0–1 is dropped and the pulse in phases 6–7 is kept.
- R5: In an external code fetch cycle (kind 2'b01), `code_rd_no` is low exactly in phases 3–5 and 9–11, which gives two read pulses per machine cycle.
- R6: In an internal code fetch cycle (kind 2'b00) or a no-bus cycle (kind 2'b11), `code_rd_no` stays high for all twelve phases.
- R7: In an external data access cycle (kind 2'b10), both read pulses are dropped and `code_rd_no` stays high for all twelve phases.
- R8: When `ale_off_i` is 1, `ext_exec_i` is 0 and `xinstr_i` is 0, `addr_strobe_o` stays low for the whole cycle.
- R9: When `ale_off_i` is 1 and `xinstr_i` is 1, the address strobe pulses as in R3 and R4.
- R10: When `ext_exec_i` is 1, `ale_off_i` has no effect and the address strobe pulses as in R3 and R4.
- R11: The cycle inputs are sampled only when `phase_o` is 11 and take effect from the next phase 0. Changes at any other phase do not affect the strobes of the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock, one phase per edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cyc_kind_i | input | 2 | Next cycle's bus use: 00 internal fetch, 01 external fetch, 10 external data, 11 none |
| xinstr_i | input | 1 | Next cycle belongs to an external data move or code-table read |
| ale_off_i | input | 1 | Address strobe disable bit |
| ext_exec_i | input | 1 | Core is executing from external program memory |
| addr_strobe_o | output | 1 | Address latch strobe, active high |
| code_rd_no | output | 1 | External code read strobe, active low |
| phase_o | output | 4 | Current phase within the machine cycle |

## Verification
The bench runs every combination of cycle kind, disable bit, external-execution flag and instruction-class flag, each for one full machine cycle, and compares both strobes phase by phase with values computed from the phase windows. The four kinds separate fetch, data and idle traffic. The three control flags separate a silenced strobe from one that is re-enabled by the instruction class or by external execution. In every cycle the inputs are scrambled during phases 5–10, which shows that only the value sampled at phase 11 counts.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;
  typedef enum logic [1:0] {
    CYC_INT   = 2'b00,
    CYC_XCODE = 2'b01,
    CYC_XDATA = 2'b10,
    CYC_IDLE  = 2'b11
  } cyc_kind_e;

  typedef struct packed {
    cyc_kind_e kind;
    logic      ale_en;
  } cyc_attr_t;
endpackage

// File: rtl/bus_phase_ctr.sv
module bus_phase_ctr #(
  parameter int PHASES = 12,
  localparam int PH_W = $clog2(PHASES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] phase_o,
  output logic            last_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ph_q <= '0;
    else if (ph_q == LAST) ph_q <= '0;
    else                 ph_q <= ph_q + PH_W'(1);
  end

  assign phase_o = ph_q;
  assign last_o  = (ph_q == LAST);
endmodule

// File: rtl/bus_cycle_latch.sv
module bus_cycle_latch
  import bus_strobe_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       last_i,
  input  logic [1:0] cyc_kind_i,
  input  logic       xinstr_i,
  input  logic       ale_off_i,
  input  logic       ext_exec_i,
  output cyc_attr_t  attr_o
);
  cyc_attr_t attr_q;

  // sampled once per machine cycle so a strobe never changes mid-window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      attr_q.kind   <= CYC_INT;
      attr_q.ale_en <= 1'b1;
    end else if (last_i) begin
      attr_q.kind   <= cyc_kind_e'(cyc_kind_i);
      attr_q.ale_en <= !ale_off_i || ext_exec_i || xinstr_i;
    end
  end

  assign attr_o = attr_q;
endmodule

// File: rtl/bus_strobe_decode.sv
module bus_strobe_decode
  import bus_strobe_pkg::*;
#(
  parameter int PHASES = 12,
  parameter int ALE_W  = 2,
  parameter int RD_OFS = 3,
  localparam int PH_W  = $clog2(PHASES),
  localparam int HALF  = PHASES / 2
) (
  input  logic [PH_W-1:0] phase_i,
  input  cyc_attr_t       attr_i,
  output logic            addr_strobe_o,
  output logic            code_rd_no
);
  logic [PHASES-1:0] ale_lo_m, ale_hi_m, rd_m;

  // constant per-phase window masks
  for (genvar p = 0; p < PHASES; p++) begin : g_mask
    assign ale_lo_m[p] = (p < ALE_W);
    assign ale_hi_m[p] = (p >= HALF) && (p < HALF + ALE_W);
    assign rd_m[p]     = ((p >= RD_OFS) && (p < HALF)) || (p >= HALF + RD_OFS);
  end

  logic in_lo, in_hi, in_rd;
  assign in_lo = ale_lo_m[phase_i];
  assign in_hi = ale_hi_m[phase_i];
  assign in_rd = rd_m[phase_i];

  assign addr_strobe_o = attr_i.ale_en &&
                         ((in_lo && attr_i.kind != CYC_XDATA) || in_hi);
  assign code_rd_no    = !(in_rd && attr_i.kind == CYC_XCODE);
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bus_strobe_pkg::*;
#(
  parameter int PHASES = 12,
  parameter int ALE_W  = 2,
  parameter int RD_OFS = 3,
  localparam int PH_W  = $clog2(PHASES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      cyc_kind_i,
  input  logic            xinstr_i,
  input  logic            ale_off_i,
  input  logic            ext_exec_i,
  output logic            addr_strobe_o,
  output logic            code_rd_no,
  output logic [PH_W-1:0] phase_o
);
  logic      last;
  cyc_attr_t attr;

  bus_phase_ctr #(.PHASES(PHASES)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_o(phase_o),
    .last_o (last)
  );

  bus_cycle_latch u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .last_i    (last),
    .cyc_kind_i(cyc_kind_i),
    .xinstr_i  (xinstr_i),
    .ale_off_i (ale_off_i),
    .ext_exec_i(ext_exec_i),
    .attr_o    (attr)
  );

  bus_strobe_decode #(.PHASES(PHASES), .ALE_W(ALE_W), .RD_OFS(RD_OFS)) u_dec (
    .phase_i      (phase_o),
    .attr_i       (attr),
    .addr_strobe_o(addr_strobe_o),
    .code_rd_no   (code_rd_no)
  );
endmodule

// File: rtl/bus_strobe_chk.sv
module bus_strobe_chk #(
  parameter int PHASES = 12,
  parameter int ALE_W  = 2,
  parameter int RD_OFS = 3,
  localparam int PH_W  = $clog2(PHASES),
  localparam int HALF  = PHASES / 2,
  localparam int LAST  = PHASES - 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      cyc_kind_i,
  input logic            xinstr_i,
  input logic            ale_off_i,
  input logic            ext_exec_i,
  input logic            addr_strobe_o,
  input logic            code_rd_no,
  input logic [PH_W-1:0] phase_o
);
  p_phase_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == LAST) |=> (phase_o == 0));

  p_phase_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != LAST) |=> (phase_o == $past(phase_o) + PH_W'(1)));

  p_ale_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_strobe_o |-> ((phase_o < ALE_W) ||
                       (phase_o >= HALF && phase_o < HALF + ALE_W)));

  p_rd_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_rd_no |-> ((phase_o >= RD_OFS && phase_o < HALF) ||
                     (phase_o >= HALF + RD_OFS)));

  p_data_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == LAST && cyc_kind_i == 2'b10) |=> !addr_strobe_o);

  p_int_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == LAST && cyc_kind_i == 2'b00) |=> ##RD_OFS code_rd_no);

  p_ale_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == LAST && ale_off_i && !ext_exec_i && !xinstr_i) |=> !addr_strobe_o);

  p_ext_override_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == LAST && ext_exec_i && cyc_kind_i != 2'b10) |=> addr_strobe_o);
endmodule

bind bus_strobe_gen bus_strobe_chk #(.PHASES(PHASES), .ALE_W(ALE_W), .RD_OFS(RD_OFS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cyc_kind_i   (cyc_kind_i),
  .xinstr_i     (xinstr_i),
  .ale_off_i    (ale_off_i),
  .ext_exec_i   (ext_exec_i),
  .addr_strobe_o(addr_strobe_o),
  .code_rd_no   (code_rd_no),
  .phase_o      (phase_o)
);

// File: tb/bus_strobe_gen_test.sv
`timescale 1ns/1ps
module bus_strobe_gen_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] cyc_kind_i = 2'b00;
  logic       xinstr_i = 1'b0, ale_off_i = 1'b0, ext_exec_i = 1'b0;
  logic       addr_strobe_o, code_rd_no;
  logic [3:0] phase_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  bus_strobe_gen uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_kind_i(cyc_kind_i),
    .xinstr_i(xinstr_i), .ale_off_i(ale_off_i), .ext_exec_i(ext_exec_i),
    .addr_strobe_o(addr_strobe_o), .code_rd_no(code_rd_no), .phase_o(phase_o)
  );

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic run_cycle(int kind, bit off, bit ext, bit xi);
    bit en;
    bit exp_ale, exp_rd_n;
    string ta, tr;
    while (phase_o != 4'd11) @(negedge clk_i);
    cyc_kind_i = 2'(kind); ale_off_i = off; ext_exec_i = ext; xinstr_i = xi;
    en = !off || ext || xi;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk_i);
      check("R1 phase", phase_o, k);
      exp_ale  = en && (((k == 0 || k == 1) && kind != 2) || k == 6 || k == 7);
      exp_rd_n = !(kind == 1 && ((k >= 3 && k <= 5) || k >= 9));
      if (!en)                       ta = "R8 ale";
      else if (kind == 2 && k < 2)   ta = "R4 ale";
      else if (off && ext)           ta = "R10 ale";
      else if (off && xi)            ta = "R9 ale";
      else                           ta = "R3 ale";
      if (kind == 1)      tr = "R5 rd";
      else if (kind == 2) tr = "R7 rd";
      else                tr = "R6 rd";
      if (k >= 5 && k <= 10) begin ta = {ta, " R11"}; tr = {tr, " R11"}; end
      check(ta, addr_strobe_o, exp_ale);
      check(tr, code_rd_no, exp_rd_n);
      // scramble mid-cycle, restore before sampling phase
      if (k == 4) begin
        cyc_kind_i = ~cyc_kind_i; ale_off_i = !off; ext_exec_i = !ext; xinstr_i = !xi;
      end
      if (k == 10) begin
        cyc_kind_i = 2'(kind); ale_off_i = off; ext_exec_i = ext; xinstr_i = xi;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R2 phase", phase_o, 0);
    check("R2 ale", addr_strobe_o, 1);
    check("R2 rd", code_rd_no, 1);
    rst_ni = 1'b1;
    for (int kind = 0; kind < 4; kind++)
      for (int m = 0; m < 8; m++)
        run_cycle(kind, m[2], m[1], m[0]);
    // back-to-back alternation of fetch and data traffic
    for (int r = 0; r < 4; r++) begin
      run_cycle(1, 1'b0, 1'b1, 1'b0);
      run_cycle(2, 1'b1, 1'b0, 1'b1);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule